// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address sequence for one SDRAM burst. A single-cycle `start` pulse supplies a start column, a burst-length code and a wrap order. Starting in the cycle after that pulse, the block presents one column per clock with `beat_valid` high. Fixed bursts of 1, 2, 4 or 8 beats wrap inside the aligned block of the burst length, in either sequential or interleaved order. In full-page mode the column walks through the whole row and wraps at the row end. Only a termination ends a full-page burst.

A controller places the block next to its command logic, or a bench uses it as the memory-side burst sequencer. A new `start` may arrive in any cycle, including in the middle of a burst, and the new burst replaces the old one. The `stop` input stands for a burst-stop or precharge and ends the burst early. The block has three states. `ST_IDLE` emits nothing. `ST_FIXED` has fixed-length beats still to emit. `ST_PAGE` is a running full-page burst. The transitions are:

- start → `ST_FIXED`, `ST_PAGE` or `ST_IDLE`; it goes to `ST_IDLE` when the length is 1.
- the last fixed beat → `ST_IDLE`.
- `stop` → `ST_IDLE`.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset `beat_valid` and `done` are 0.
- R2: `blen_sel` codes 000, 001, 010 and 011 give bursts of exactly 1, 2, 4 and 8 beats. The beats come on consecutive cycles, and the first beat, at `start_col`, appears in the cycle after `start` is sampled.
- R3: With `wrap_ilv`=0, beat i carries the start column's low log2(BL) bits plus i, modulo BL. All higher column bits stay equal to the start column.
- R4: With `wrap_ilv`=1, beat i carries the start column's low log2(BL) bits XOR i. All higher column bits stay equal to the start column.
- R5: When `blen_sel[2]`=1 (full page), the column rises by one each cycle modulo 2^COL_W, and the burst never ends by itself.
- R6: For fixed lengths, `done` is 1 exactly with the final beat. For length 1 this is the single beat.
- R7: When `stop` is sampled during a burst, `beat_valid` is 0 in the next cycle. In that cycle `done` is 1 for a full-page burst and 0 for a fixed burst.
- R8: A `start` sampled during a burst restarts the sequence from the new column with the new settings. When `start` and `stop` are sampled together, `start` wins.
- R9: A `stop` sampled while no burst runs has no effect: `beat_valid` and `done` stay 0.
- R10: `done` is a single-cycle pulse unless a new `start` was sampled at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | COL_W | Start column |
| blen_sel | input | 3 | Burst length: [2]=1 full page, else 2^[1:0] beats |
| wrap_ilv | input | 1 | 0 sequential, 1 interleaved |
| stop | input | 1 | Terminate the running burst |
| col | output | COL_W | Current column |
| beat_valid | output | 1 | `col` is a burst beat this cycle |
| done | output | 1 | Final beat, or full-page termination |

## Verification
The assertions assume that `blen_sel` and `wrap_ilv` matter only in a cycle with `start` high, and that `stop` is a level sampled at each edge. They also assume `start_col` is stable whenever `start` is high. The bench changes inputs only on falling edges. It applies settings only together with `start`, and it drives `stop` for exactly one cycle at the beat where the burst is meant to end. The test cases cover mid-burst restarts, a `start` and `stop` sampled together, and a `stop` while idle.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_FIXED, ST_PAGE} cg_state_e;

    localparam int IDX_W = 3;

    function automatic logic [IDX_W-1:0] len_mask(input logic [1:0] lg);
        logic [IDX_W-1:0] m;
        m = '0;
        for (int b = 0; b < IDX_W; b++)
            if (b < int'(lg)) m[b] = 1'b1;
        return m;
    endfunction

    function automatic logic [IDX_W-1:0] wrap_low(
        input logic [IDX_W-1:0] base_low,
        input logic [IDX_W-1:0] idx,
        input logic [IDX_W-1:0] mask,
        input logic             ilv
    );
        logic [IDX_W-1:0] v;
        if (ilv) v = base_low ^ idx;
        else     v = base_low + idx;
        return v & mask;
    endfunction
endpackage

// File: rtl/colgen_fsm.sv
module colgen_fsm
    import colgen_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic [2:0]    blen_sel,
    output logic          load,
    output logic          adv_fixed,
    output logic          adv_page,
    output logic [IW-1:0] idx,
    output logic [IW-1:0] mask,
    output logic          beat_valid,
    output logic          done
);
    cg_state_e     state_q, state_d;
    logic [IW-1:0] idx_q;
    logic [1:0]    lg_q;
    logic [IW-1:0] mask_new;
    logic          last_hit;

    assign mask_new  = len_mask(blen_sel[1:0]);
    assign mask      = len_mask(lg_q);
    assign idx       = idx_q;
    assign last_hit  = (idx_q == mask);
    assign load      = start;
    assign adv_fixed = !start && !stop && (state_q == ST_FIXED);
    assign adv_page  = !start && !stop && (state_q == ST_PAGE);

    always_comb begin
        state_d = state_q;
        if (start) begin
            if (blen_sel[2])        state_d = ST_PAGE;
            else if (mask_new == 0) state_d = ST_IDLE;
            else                    state_d = ST_FIXED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_FIXED: state_d = (stop || last_hit) ? ST_IDLE : ST_FIXED;
                ST_PAGE:  state_d = stop ? ST_IDLE : ST_PAGE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_valid <= 1'b0;
            done       <= 1'b0;
            idx_q      <= '0;
            lg_q       <= '0;
        end else if (start) begin
            beat_valid <= 1'b1;
            done       <= !blen_sel[2] && (mask_new == 0);
            idx_q      <= IW'(1);
            lg_q       <= blen_sel[1:0];
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    beat_valid <= 1'b0;
                    done       <= 1'b0;
                end
                ST_FIXED: begin
                    beat_valid <= !stop;
                    done       <= !stop && last_hit;
                    idx_q      <= idx_q + IW'(1);
                end
                ST_PAGE: begin
                    beat_valid <= !stop;
                    done       <= stop;
                end
                default: begin
                    beat_valid <= 1'b0;
                    done       <= 1'b0;
                end
            endcase
        end
    end

    // R8: every accepted start yields a beat next cycle
    a_r8_start_beat: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> beat_valid);
    // R7: termination silences the next cycle
    a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start && state_q != ST_IDLE) |=> !beat_valid);
    // R6: final fixed beat carries done
    a_r6_done_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIXED && !start && !stop && last_hit) |=> (done && beat_valid));
    // R9: idle stays quiet without start
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> (!beat_valid && !done));
    // R10: done lasts one cycle unless restarted
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
    import colgen_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int IW    = IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv_fixed,
    input  logic             adv_page,
    input  logic [COL_W-1:0] start_col,
    input  logic             wrap_ilv,
    input  logic [IW-1:0]    idx,
    input  logic [IW-1:0]    mask,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] base_q, col_q, step_col;
    logic             ilv_q;
    logic [IW-1:0]    low;

    assign low      = wrap_low(base_q[IW-1:0], idx, mask, ilv_q);
    assign step_col = {base_q[COL_W-1:IW], (base_q[IW-1:0] & ~mask) | low};
    assign col      = col_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            col_q  <= '0;
            ilv_q  <= 1'b0;
        end else if (load) begin
            base_q <= start_col;
            col_q  <= start_col;
            ilv_q  <= wrap_ilv;
        end else if (adv_fixed) begin
            col_q  <= step_col;
        end else if (adv_page) begin
            col_q  <= col_q + COL_W'(1);
        end
    end

    // R5: full page steps by one, wrapping at row end
    a_r5_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        adv_page |=> (col == $past(col) + COL_W'(1)));
    // R3: sequential offset from base equals beat index
    a_r3_seq_order: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_fixed && !ilv_q) |=> ((col[COL_W-1:IW] == base_q[COL_W-1:IW]) &&
            (((col[IW-1:0] - base_q[IW-1:0]) & $past(mask)) == $past(idx))));
    // R4: interleaved low bits differ from base by beat index
    a_r4_ilv_order: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_fixed && ilv_q) |=> ((col[COL_W-1:IW] == base_q[COL_W-1:IW]) &&
            ((col[IW-1:0] ^ base_q[IW-1:0]) == $past(idx))));
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       blen_sel,
    input  logic             wrap_ilv,
    input  logic             stop,
    output logic [COL_W-1:0] col,
    output logic             beat_valid,
    output logic             done
);
    logic          load, adv_fixed, adv_page;
    logic [IDX_W-1:0] idx, mask;

    colgen_fsm #(.IW(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .blen_sel(blen_sel), .load(load), .adv_fixed(adv_fixed),
        .adv_page(adv_page), .idx(idx), .mask(mask),
        .beat_valid(beat_valid), .done(done)
    );

    colgen_addr #(.COL_W(COL_W), .IW(IDX_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .adv_fixed(adv_fixed),
        .adv_page(adv_page), .start_col(start_col), .wrap_ilv(wrap_ilv),
        .idx(idx), .mask(mask), .col(col)
    );

    // R1: quiet right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!beat_valid && !done));
endmodule

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] start_col = '0;
    logic [2:0]   blen_sel = '0;
    logic         wrap_ilv = 1'b0;
    logic         stop = 1'b0;
    logic [W-1:0] col;
    logic         beat_valid, done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        bit         bv;
        bit [W-1:0] c;
        bit         d;
        string      req;
    } item_t;
    item_t expq[$];

    always #5 clk = ~clk;

    sdram_burst_colgen #(.COL_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .blen_sel(blen_sel), .wrap_ilv(wrap_ilv), .stop(stop),
        .col(col), .beat_valid(beat_valid), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit [W-1:0] exp_col(input bit [W-1:0] s, input bit [2:0] bl,
                                           input bit ilv, input int i);
        bit [W-1:0] m, lo;
        if (bl[2]) return W'(int'(s) + i);
        m  = W'((1 << bl[1:0]) - 1);
        lo = ilv ? ((s & m) ^ W'(i)) : (((s & m) + W'(i)) & m);
        return (s & ~m) | lo;
    endfunction

    function automatic string tag(input bit [2:0] bl, input bit ilv);
        if (bl[2]) return "R5";
        return ilv ? "R4" : "R3";
    endfunction

    // push the expected beats for a burst that emits n beats
    task automatic push_beats(input bit [W-1:0] s, input bit [2:0] bl, input bit ilv,
                              input int n, input bit natural);
        int len;
        len = 1 << bl[1:0];
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.bv  = 1;
            it.c   = exp_col(s, bl, ilv, i);
            it.d   = natural && !bl[2] && (i == len - 1);
            it.req = (i == n - 1 && it.d) ? "R6" : tag(bl, ilv);
            expq.push_back(it);
        end
    endtask

    // k < 0: run to natural end; else stop after k beats
    task automatic burst(input bit [W-1:0] s, input bit [2:0] bl, input bit ilv,
                         input int k);
        int n;
        n = (k < 0) ? (1 << bl[1:0]) : k;
        push_beats(s, bl, ilv, n, k < 0);
        if (k >= 0) begin
            item_t it;
            it.bv = 0; it.c = '0; it.d = bl[2]; it.req = "R7";
            if (bl[2]) expq.push_back(it);
        end
        start = 1; start_col = s; blen_sel = bl; wrap_ilv = ilv;
        @(negedge clk);
        start = 0;
        repeat (n - 1) @(negedge clk);
        if (k >= 0) begin
            stop = 1;
            @(negedge clk);
            stop = 0;
            chk(beat_valid == 0, "R7", beat_valid, 0);
        end
        @(negedge clk);
    endtask

    // monitor: compares every active output cycle with the queue
    always @(negedge clk) begin
        if (rst_n && !finished && (beat_valid || done)) begin
            if (expq.size() == 0) begin
                chk(0, "R9", {beat_valid, done}, 0);
            end else begin
                item_t it;
                it = expq.pop_front();
                chk(beat_valid == it.bv, it.req, beat_valid, it.bv);
                chk(done == it.d, it.req, done, it.d);
                if (it.bv) chk(col == it.c, it.req, col, it.c);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(beat_valid == 0 && done == 0, "R1", {beat_valid, done}, 0);
        rst_n = 1;
        @(negedge clk);

        // R2 lengths, R3 sequential
        burst(10'h123, 3'b000, 0, -1);
        burst(10'h0F5, 3'b001, 0, -1);
        burst(10'h2A6, 3'b010, 0, -1);
        burst(10'h3FD, 3'b011, 0, -1);
        chk(done == 0, "R10", done, 0);
        // R4 interleave
        burst(10'h1F2, 3'b010, 1, -1);
        burst(10'h0B5, 3'b011, 1, -1);
        burst(10'h047, 3'b001, 1, -1);
        // R5 full page across row end, R7 done on termination
        burst(10'h3FD, 3'b100, 0, 6);
        chk(done == 0, "R10", done, 0);
        // R7 fixed burst aborted
        burst(10'h2A3, 3'b011, 0, 3);
        burst(10'h111, 3'b010, 1, 1);

        // R8 restart mid-burst
        push_beats(10'h305, 3'b011, 0, 2, 0);
        push_beats(10'h0C2, 3'b010, 1, 4, 1);
        start = 1; start_col = 10'h305; blen_sel = 3'b011; wrap_ilv = 0;
        @(negedge clk);
        start = 0;
        @(negedge clk);
        start = 1; start_col = 10'h0C2; blen_sel = 3'b010; wrap_ilv = 1;
        @(negedge clk);
        start = 0;
        repeat (4) @(negedge clk);

        // R8 start and stop together: start wins
        push_beats(10'h0A9, 3'b010, 0, 4, 1);
        start = 1; stop = 1; start_col = 10'h0A9; blen_sel = 3'b010; wrap_ilv = 0;
        @(negedge clk);
        start = 0; stop = 0;
        repeat (4) @(negedge clk);

        // R6 back-to-back single-beat bursts
        push_beats(10'h200, 3'b000, 0, 1, 1);
        push_beats(10'h201, 3'b000, 0, 1, 1);
        start = 1; start_col = 10'h200; blen_sel = 3'b000;
        @(negedge clk);
        start_col = 10'h201;
        @(negedge clk);
        start = 0;
        @(negedge clk);

        // R9 stop while idle
        stop = 1;
        repeat (2) @(negedge clk);
        stop = 0;
        chk(beat_valid == 0 && done == 0, "R9", {beat_valid, done}, 0);
        @(negedge clk);
        chk(beat_valid == 0 && done == 0, "R9", {beat_valid, done}, 0);

        chk(expq.size() == 0, "R2", expq.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule